// File: doc/BRIEF.md
# Bus-Mapped Transfer Register

A 16-bit storage register that sits on a shared 16-bit data bus. It loads from either half of the bus and drives onto either half of the bus. Each of the four transfer paths (lower write, upper write, lower read, upper read) has its own bit mapping, fixed when the block is built. A mapping names, for each of the eight lines in its half, which register bit that line belongs to. Any line or register bit that no entry covers takes a constant fill bit configured for that path.

The register contents are always present on a parallel output, so surrounding logic can decode them directly. A transfer-disable input stops the register from driving the bus while a write still completes. With it, several registers can each be given read and write commands in one step, and all of them capture the value a single other source places on the bus. Bus arbitration and the sequencer that issues commands are outside the block.

Top module: `xfer_reg`

## Requirements
- R1: `rst_ni` low clears the register to zero at once, without waiting for a clock edge, and holds it at zero while low.
- R2: `reg_o` always equals the stored register value, whatever the bus and the read commands are doing.
- R3: On a rising edge with only the lower write applied, for each lower bus line k (bus bit k) whose map entry r is below 16, register bit r takes bus bit k. An entry of 16 or more means the line is unmapped. Register bits that no entry names take the lower write fill bit.
- R4: On a rising edge with only the upper write applied, the same rule applies to upper lines k (bus bit 8+k) with the upper write map and the upper write fill bit.
- R5: With both writes applied, a register bit named by the upper map takes the upper value. Otherwise a bit named by the lower map takes the lower value. A bit named by neither takes the lower write fill bit.
- R6: While the lower read is legal, `bus_oe_o[0]` is 1 and `bus_o[k]` equals register bit r for map entry r below 16, or the lower read fill bit for an unmapped entry.
- R7: While the upper read is legal, `bus_oe_o[1]` is 1 and `bus_o[8+k]` follows the upper read map and fill in the same way.
- R8: Both reads may be applied together, and then both halves are driven at the same time.
- R9: A bus half whose enable bit is 0 outputs all zeros on its eight `bus_o` lines.
- R10: Any read together with any write while `xfer_dis_i` is low raises `conflict_o`. Neither half is then driven and the register keeps its value.
- R11: While `xfer_dis_i` is high, neither half is driven and `conflict_o` stays low, but writes complete as in R3 to R5, even when reads are also applied.
- R12: Without a write command the register holds its value across clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 16 | Value present on the shared bus |
| wr_lo_i | input | 1 | Load from the lower bus half |
| wr_hi_i | input | 1 | Load from the upper bus half |
| rd_lo_i | input | 1 | Drive the lower bus half |
| rd_hi_i | input | 1 | Drive the upper bus half |
| xfer_dis_i | input | 1 | Suppress bus drive and allow fan-out loads |
| bus_o | output | 16 | Mapped read data, zero on undriven halves |
| bus_oe_o | output | 2 | Drive enable per half (bit 0 lower, bit 1 upper) |
| reg_o | output | 16 | Parallel register contents |
| conflict_o | output | 1 | Illegal read-and-write command detected |

## Verification
The block is built with sparse, overlapping, non-identity maps and mixed fill bits, so a wrong lane index, a swapped fill or a lost priority gives a visible bit error. Each write path alone is swept over all 256 values of its own half, which tests every mapped line and every fill position. Both writes together are swept the same way, which separates upper priority from lower fallback on the overlapping bits. A further sweep covers every combination of the four commands and the disable input with varied bus data. This tells the conflict case apart from the fan-out case and from the idle hold, and it checks the read lanes against the stored value each time.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int XR_W     = 16;
  localparam int XR_HALF  = XR_W / 2;
  localparam int XR_IDX_W = $clog2(XR_W) + 1;
  localparam int XR_NONE  = XR_W;

  typedef logic [XR_IDX_W-1:0] xr_idx_t;
  typedef xr_idx_t [XR_HALF-1:0] xr_map_t;

  typedef struct packed {
    logic [XR_W-1:0] val;
    logic [XR_W-1:0] hit;
  } xr_load_t;

  function automatic xr_map_t xr_ident_map(input int base);
    xr_map_t m;
    for (int k = 0; k < XR_HALF; k++) m[k] = xr_idx_t'(base + k);
    return m;
  endfunction
endpackage

// File: rtl/xr_wr_map.sv
module xr_wr_map
  import xr_pkg::*;
#(
  parameter xr_map_t MAP  = xr_ident_map(0),
  parameter logic    FILL = 1'b0
) (
  input  logic [XR_HALF-1:0] lane_i,
  output xr_load_t           load_o
);
  // later lanes win if two entries name the same bit
  always_comb begin
    load_o.val = {XR_W{FILL}};
    load_o.hit = '0;
    for (int k = 0; k < XR_HALF; k++) begin
      if (MAP[k] < xr_idx_t'(XR_NONE)) begin
        load_o.val[MAP[k][XR_IDX_W-2:0]] = lane_i[k];
        load_o.hit[MAP[k][XR_IDX_W-2:0]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xr_rd_map.sv
module xr_rd_map
  import xr_pkg::*;
#(
  parameter xr_map_t MAP  = xr_ident_map(0),
  parameter logic    FILL = 1'b0
) (
  input  logic [XR_W-1:0]    reg_i,
  input  logic               en_i,
  output logic [XR_HALF-1:0] lane_o
);
  always_comb begin
    lane_o = '0;
    if (en_i) begin
      for (int k = 0; k < XR_HALF; k++) begin
        if (MAP[k] < xr_idx_t'(XR_NONE)) lane_o[k] = reg_i[MAP[k][XR_IDX_W-2:0]];
        else                             lane_o[k] = FILL;
      end
    end
  end
endmodule

// File: rtl/xr_cmd_guard.sv
module xr_cmd_guard (
  input  logic [1:0] wr_i,
  input  logic [1:0] rd_i,
  input  logic       dis_i,
  output logic [1:0] wr_en_o,
  output logic [1:0] rd_en_o,
  output logic       conflict_o
);
  // with dis_i high a read is a no-op, so read+write is a fan-out load
  assign conflict_o = (|rd_i) & (|wr_i) & ~dis_i;
  assign rd_en_o    = rd_i & {2{~dis_i & ~conflict_o}};
  assign wr_en_o    = wr_i & {2{~conflict_o}};
endmodule

// File: rtl/xfer_reg.sv
module xfer_reg
  import xr_pkg::*;
#(
  parameter xr_map_t WR_LO_MAP  = xr_ident_map(0),
  parameter xr_map_t WR_HI_MAP  = xr_ident_map(XR_HALF),
  parameter xr_map_t RD_LO_MAP  = xr_ident_map(0),
  parameter xr_map_t RD_HI_MAP  = xr_ident_map(XR_HALF),
  parameter logic    WR_LO_FILL = 1'b0,
  parameter logic    WR_HI_FILL = 1'b0,
  parameter logic    RD_LO_FILL = 1'b0,
  parameter logic    RD_HI_FILL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XR_W-1:0]   bus_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic              xfer_dis_i,
  output logic [XR_W-1:0]   bus_o,
  output logic [1:0]        bus_oe_o,
  output logic [XR_W-1:0]   reg_o,
  output logic              conflict_o
);
  logic [XR_W-1:0] q, d;
  logic [1:0]      wr_en, rd_en;
  xr_load_t        ld [2];

  xr_cmd_guard u_guard (
    .wr_i       ({wr_hi_i, wr_lo_i}),
    .rd_i       ({rd_hi_i, rd_lo_i}),
    .dis_i      (xfer_dis_i),
    .wr_en_o    (wr_en),
    .rd_en_o    (rd_en),
    .conflict_o (conflict_o)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam xr_map_t WMAP  = (h == 0) ? WR_LO_MAP  : WR_HI_MAP;
    localparam xr_map_t RMAP  = (h == 0) ? RD_LO_MAP  : RD_HI_MAP;
    localparam logic    WFILL = (h == 0) ? WR_LO_FILL : WR_HI_FILL;
    localparam logic    RFILL = (h == 0) ? RD_LO_FILL : RD_HI_FILL;

    xr_wr_map #(.MAP(WMAP), .FILL(WFILL)) u_wr (
      .lane_i (bus_i[h*XR_HALF +: XR_HALF]),
      .load_o (ld[h])
    );

    xr_rd_map #(.MAP(RMAP), .FILL(RFILL)) u_rd (
      .reg_i  (q),
      .en_i   (rd_en[h]),
      .lane_o (bus_o[h*XR_HALF +: XR_HALF])
    );
  end

  // upper map wins per bit; bits neither maps fall to the lower load (its fill)
  always_comb begin
    case (wr_en)
      2'b01:   d = ld[0].val;
      2'b10:   d = ld[1].val;
      2'b11:   d = (ld[1].hit & ld[1].val) | (~ld[1].hit & ld[0].val);
      default: d = q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign reg_o    = q;
  assign bus_oe_o = rd_en;
endmodule

// File: rtl/xfer_reg_chk.sv
module xfer_reg_chk
  import xr_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_lo_i,
  input logic            wr_hi_i,
  input logic            rd_lo_i,
  input logic            rd_hi_i,
  input logic            xfer_dis_i,
  input logic [XR_W-1:0] bus_o,
  input logic [1:0]      bus_oe_o,
  input logic [XR_W-1:0] reg_o,
  input logic            conflict_o
);
  assert_conflict_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> reg_o == $past(reg_o));

  assert_conflict_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> bus_oe_o == 2'b00);

  assert_dis_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_dis_i |-> (bus_oe_o == 2'b00 && !conflict_o));

  assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lo_i || wr_hi_i) |=> $stable(reg_o));

  assert_lo_oe_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o[0] |-> rd_lo_i);

  assert_hi_oe_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o[1] |-> rd_hi_i);

  assert_lo_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o[0] |-> bus_o[XR_HALF-1:0] == '0);

  assert_hi_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o[1] |-> bus_o[XR_W-1:XR_HALF] == '0);
endmodule

bind xfer_reg xfer_reg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_lo_i    (wr_lo_i),
  .wr_hi_i    (wr_hi_i),
  .rd_lo_i    (rd_lo_i),
  .rd_hi_i    (rd_hi_i),
  .xfer_dis_i (xfer_dis_i),
  .bus_o      (bus_o),
  .bus_oe_o   (bus_oe_o),
  .reg_o      (reg_o),
  .conflict_o (conflict_o)
);

// File: tb/xfer_reg_tb.sv
module xfer_reg_tb;
  import xr_pkg::*;

  function automatic xr_map_t mk_wl();
    xr_map_t m;
    for (int k = 0; k < XR_HALF; k++) m[k] = (k == 7) ? xr_idx_t'(XR_NONE) : xr_idx_t'(2*k + 1);
    return m;
  endfunction
  function automatic xr_map_t mk_wh();
    xr_map_t m;
    for (int k = 0; k < XR_HALF; k++)
      m[k] = (k < 6) ? xr_idx_t'((3*k) % 16) : (k == 6) ? xr_idx_t'(XR_NONE) : xr_idx_t'(2);
    return m;
  endfunction
  function automatic xr_map_t mk_rl();
    xr_map_t m;
    for (int k = 0; k < XR_HALF; k++) m[k] = (k == 2) ? xr_idx_t'(XR_NONE) : xr_idx_t'(15 - k);
    return m;
  endfunction
  function automatic xr_map_t mk_rh();
    xr_map_t m;
    for (int k = 0; k < XR_HALF; k++) m[k] = (k < 6) ? xr_idx_t'(k + 4) : xr_idx_t'(XR_NONE);
    return m;
  endfunction

  localparam xr_map_t TB_WL = mk_wl();
  localparam xr_map_t TB_WH = mk_wh();
  localparam xr_map_t TB_RL = mk_rl();
  localparam xr_map_t TB_RH = mk_rh();
  localparam logic F_WL = 1'b1, F_WH = 1'b0, F_RL = 1'b1, F_RH = 1'b0;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [15:0] bus_i = '0;
  logic wr_lo = 0, wr_hi = 0, rd_lo = 0, rd_hi = 0, dis = 0;
  logic [15:0] bus_o, reg_o;
  logic [1:0]  bus_oe;
  logic        conflict;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] model = '0;

  always #2 clk = ~clk;

  xfer_reg #(
    .WR_LO_MAP(TB_WL), .WR_HI_MAP(TB_WH), .RD_LO_MAP(TB_RL), .RD_HI_MAP(TB_RH),
    .WR_LO_FILL(F_WL), .WR_HI_FILL(F_WH), .RD_LO_FILL(F_RL), .RD_HI_FILL(F_RH)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_i(bus_i),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .rd_lo_i(rd_lo), .rd_hi_i(rd_hi),
    .xfer_dis_i(dis), .bus_o(bus_o), .bus_oe_o(bus_oe), .reg_o(reg_o),
    .conflict_o(conflict)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] half_load(input xr_map_t m, input logic fill, input logic [7:0] lane,
                                            output logic [15:0] hit);
    logic [15:0] v = {16{fill}};
    hit = '0;
    for (int k = 0; k < 8; k++)
      if (int'(m[k]) < 16) begin v[int'(m[k])] = lane[k]; hit[int'(m[k])] = 1'b1; end
    return v;
  endfunction

  function automatic logic [15:0] exp_write(input logic [15:0] cur, input logic [15:0] b, input bit wl, input bit wh);
    logic [15:0] lv, hv, lm, hm;
    lv = half_load(TB_WL, F_WL, b[7:0], lm);
    hv = half_load(TB_WH, F_WH, b[15:8], hm);
    if (wl && wh) begin
      for (int r = 0; r < 16; r++) lv[r] = hm[r] ? hv[r] : lv[r];
      return lv;
    end
    if (wl) return lv;
    if (wh) return hv;
    return cur;
  endfunction

  function automatic logic [7:0] exp_lane(input xr_map_t m, input logic fill, input logic [15:0] rv);
    logic [7:0] o;
    for (int k = 0; k < 8; k++) o[k] = (int'(m[k]) < 16) ? rv[int'(m[k])] : fill;
    return o;
  endfunction

  task automatic run(input bit wl, input bit wh, input bit rl, input bit rh, input bit ds, input logic [15:0] b);
    bit wr, rd, cf, dlo, dhi;
    logic [15:0] eb;
    string tb_tag, tr_tag;
    @(negedge clk);
    wr_lo = wl; wr_hi = wh; rd_lo = rl; rd_hi = rh; dis = ds; bus_i = b;
    wr = wl | wh; rd = rl | rh;
    cf  = rd && wr && !ds;
    dlo = rl && !ds && !cf;
    dhi = rh && !ds && !cf;
    eb  = {dhi ? exp_lane(TB_RH, F_RH, model) : 8'h00, dlo ? exp_lane(TB_RL, F_RL, model) : 8'h00};
    if (cf)             tb_tag = "R10";
    else if (ds)        tb_tag = "R11";
    else if (rl && rh)  tb_tag = "R8";
    else if (rl)        tb_tag = "R6";
    else if (rh)        tb_tag = "R7";
    else                tb_tag = "R9";
    #1;
    chk(ds ? "R11" : "R10", "conflict", {15'd0, conflict}, {15'd0, cf});
    chk(tb_tag, "bus_oe", {14'd0, bus_oe}, {14'd0, dhi, dlo});
    chk(tb_tag, "bus_o", bus_o, eb);
    if (cf)                tr_tag = "R10";
    else if (!wr)          tr_tag = "R12";
    else if (ds && rd)     tr_tag = "R11";
    else if (wl && wh)     tr_tag = "R5";
    else if (wl)           tr_tag = "R3";
    else                   tr_tag = "R4";
    if (!cf) model = exp_write(model, b, wl, wh);
    @(posedge clk); #1;
    chk(tr_tag, "reg_o", reg_o, model);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    #5;
    chk("R1", "reg_o in reset", reg_o, 16'h0000);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    #1 chk("R1", "reg_o after release", reg_o, 16'h0000);
    chk("R9", "bus_o idle", bus_o, 16'h0000);

    for (int v = 0; v < 256; v++) run(1, 0, 0, 0, 0, {~v[7:0], v[7:0]});
    for (int v = 0; v < 256; v++) run(0, 1, 0, 0, 0, {v[7:0], ~v[7:0]});
    for (int v = 0; v < 256; v++) run(1, 1, 0, 0, 0, {v[7:0], v[7:0] ^ 8'h5a});

    for (int i = 0; i < 2048; i++) begin
      logic [15:0] b = 16'((i * 40503 + 12345) ^ (i << 7));
      run(i[0], i[1], i[2], i[3], i[4], b);
    end

    // R2: output follows storage, not the bus
    run(1, 1, 0, 0, 0, 16'hffff);
    @(negedge clk);
    wr_lo = 0; wr_hi = 0; rd_lo = 0; rd_hi = 0; dis = 0;
    bus_i = 16'h1234;
    #1 chk("R2", "reg_o with idle bus", reg_o, model);
    bus_i = 16'hedcb; rd_lo = 1; rd_hi = 1;
    #1 chk("R2", "reg_o while reading", reg_o, model);

    // R1: asynchronous clear, held while low
    rd_lo = 0; rd_hi = 0;
    #0.5 rst_ni = 1'b0;
    #0.5 chk("R1", "reg_o async clear", reg_o, 16'h0000);
    wr_lo = 1; wr_hi = 1; bus_i = 16'hffff;
    @(posedge clk); #1;
    chk("R1", "reg_o held in reset", reg_o, 16'h0000);
    @(negedge clk);
    wr_lo = 0; wr_hi = 0;
    rst_ni = 1'b1;
    model = '0;
    run(0, 0, 1, 1, 0, 16'h0f0f);

    done = 1;
    summary();
    $finish;
  end
endmodule